// File: doc/BRIEF.md
# Six-Operation Multicycle Processor Core

A small programmable core built from a state-machine controller and a datapath. It holds sixteen 16-bit working registers. The register file has two read ports and one write port. A 256-word data space is split between RAM, memory-mapped input bytes and output bytes. A 256-word program store is filled through a write port while reset is held. The core then starts at program address 0. It executes six operations: load from memory, store to memory, add, subtract, load an 8-bit constant, and branch when a register is zero.

Each instruction passes through three controller states: fetch, decode and one execute state chosen by the opcode. Fetch latches the instruction word and advances the program counter. Decode selects the execute state. The execute state drives the register-file write, the memory write or the program-counter load. The instruction word has a 4-bit operation field in bits 15..12 and a destination/first register field in bits 11..8. Bits 7..4 and 3..0 name the two source registers. Bits 7..0 serve instead as an 8-bit address, constant or branch offset.

Top module: `sixop_cpu`

## Requirements
- R1: While reset is low, the program counter reads 0, every output byte reads 0 and the fetch strobe is low. On the first clock edge after release, the core enters fetch at address 0.
- R2: Every instruction takes exactly three cycles. The fetch strobe is high one cycle in three, and each fetch advances the program counter by one.
- R3: Opcode 0000 copies data word D[bits 7..0] into register [bits 11..8]. Opcode 0001 writes that register into D[bits 7..0]. RAM at addresses 0..239 keeps what was stored.
- R4: Opcode 0010 writes reg[bits 7..4] + reg[bits 3..0] into reg[bits 11..8], wrapping modulo 2^16.
- R5: Opcode 0100 writes reg[bits 7..4] − reg[bits 3..0] into reg[bits 11..8], wrapping modulo 2^16.
- R6: Opcode 0011 writes bits 7..0 into reg[bits 11..8], zero-extended to 16 bits.
- R7: Opcode 0101 tests reg[bits 11..8]. If that register is zero, the next instruction comes from the branch's own address plus bits 7..0 taken as a signed two's-complement offset. Otherwise execution continues in sequence.
- R8: A load from address 240+k (k = 0..7) returns input byte k (io_in[8k+7:8k]) zero-extended. Stores to 240..247 change nothing.
- R9: A store to address 248+k (k = 0..7) sets output byte k (io_out[8k+7:8k]) to the low 8 bits of the register. The output bytes change only on such a store.
- R10: Opcodes 0110 through 1111 change no register, memory word or output byte, and execution continues with the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_we | input | 1 | Program store write enable |
| imem_addr | input | 8 | Program store write address |
| imem_data | input | 16 | Program store write data |
| io_in | input | 64 | Eight memory-mapped input bytes |
| io_out | output | 64 | Eight memory-mapped output bytes |
| pc_o | output | 8 | Program counter |
| fetch_o | output | 1 | High while the controller is in fetch |

## Verification
The bound checker watches, on every cycle, the reset values, the one-in-three spacing of fetches, the program-counter step at each fetch, and program-counter holding outside fetch and branch. It also watches that output bytes stay still except after a memory write. The arithmetic results, the sign of branch offsets, zero extension, input reads, ignored stores and undefined opcodes only show at the ports after whole programs run. The bench sweeps pairs of operands through add, subtract and a RAM round trip. It also runs a fixed program of forward, backward and untaken branches against two input patterns.

// File: rtl/sixop_pkg.sv
package sixop_pkg;

   localparam int unsigned INSTR_W = 16;
   localparam int unsigned IMM_W   = 8;

   localparam logic [3:0] OPC_LOAD  = 4'h0;
   localparam logic [3:0] OPC_STORE = 4'h1;
   localparam logic [3:0] OPC_ADD   = 4'h2;
   localparam logic [3:0] OPC_LDC   = 4'h3;
   localparam logic [3:0] OPC_SUB   = 4'h4;
   localparam logic [3:0] OPC_JMPZ  = 4'h5;

   typedef enum logic [1:0] {
      ALU_PASS = 2'b00,
      ALU_ADD  = 2'b01,
      ALU_SUB  = 2'b10
   } alu_sel_e;

   typedef enum logic [1:0] {
      WD_MEM = 2'b00,
      WD_ALU = 2'b01,
      WD_IMM = 2'b10
   } wsel_e;

   typedef enum logic [3:0] {
      ST_INIT, ST_FETCH, ST_DECODE,
      ST_LOAD, ST_STORE, ST_ADD, ST_LDC, ST_SUB, ST_JMPZ, ST_NOP
   } state_e;

   typedef struct packed {
      logic     pc_clr;
      logic     pc_inc;
      logic     pc_ld;
      logic     ir_ld;
      logic     d_wr;
      logic     rf_we;
      logic     p_from_ra;
      wsel_e    wsel;
      alu_sel_e alu;
   } ctl_t;

endpackage

// File: rtl/sixop_rf.sv
module sixop_rf #(
   parameter int unsigned DW    = 16,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] p_addr,
   output logic [DW-1:0] p_data,
   input  logic [AW-1:0] q_addr,
   output logic [DW-1:0] q_data
);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("sixop_rf: DEPTH must be a power of two");
   end

   logic [DW-1:0] entry [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      localparam logic [AW-1:0] SLOT = AW'(i);
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   q <= '0;
         else if (we && waddr == SLOT) q <= wdata;
      end
      assign entry[i] = q;
   end

   assign p_data = entry[p_addr];
   assign q_data = entry[q_addr];

endmodule

// File: rtl/sixop_alu.sv
module sixop_alu
   import sixop_pkg::*;
#(
   parameter int unsigned DW = 16
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  alu_sel_e      sel,
   output logic [DW-1:0] y
);

   always_comb begin
      unique case (sel)
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         default: y = a;
      endcase
   end

endmodule

// File: rtl/sixop_dmem.sv
module sixop_dmem #(
   parameter int unsigned DW       = 16,
   parameter int unsigned DEPTH    = 256,
   parameter int unsigned IN_BASE  = 240,
   parameter int unsigned OUT_BASE = 248,
   parameter int unsigned IO_W     = 8,
   parameter int unsigned IO_PORTS = 8,
   localparam int unsigned AW      = $clog2(DEPTH),
   localparam int unsigned IOV_W   = IO_W * IO_PORTS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata,
   input  logic [IOV_W-1:0] io_in,
   output logic [IOV_W-1:0] io_out
);

   if (IN_BASE + IO_PORTS > OUT_BASE) begin : g_bad_in
      $error("sixop_dmem: input window overlaps output window");
   end
   if (OUT_BASE + IO_PORTS != DEPTH) begin : g_bad_out
      $error("sixop_dmem: output window must end at the top address");
   end
   if (IO_W >= DW) begin : g_bad_w
      $error("sixop_dmem: IO_W must be narrower than DW");
   end

   localparam int unsigned RAM_DEPTH = IN_BASE;
   localparam logic [AW-1:0] IN_LO   = AW'(IN_BASE);

   logic [DW-1:0] ram [RAM_DEPTH];

   always_ff @(posedge clk) begin
      if (we && addr < IN_LO) ram[addr] <= wdata;
   end

   for (genvar k = 0; k < IO_PORTS; k++) begin : g_out
      localparam logic [AW-1:0] SLOT = AW'(OUT_BASE + k);
      logic [IO_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 q <= '0;
         else if (we && addr == SLOT) q <= wdata[IO_W-1:0];
      end
      assign io_out[k*IO_W +: IO_W] = q;
   end

   always_comb begin
      rdata = '0;
      if (addr < IN_LO) begin
         rdata = ram[addr];
      end else begin
         for (int k = 0; k < IO_PORTS; k++) begin
            if (addr == AW'(IN_BASE + k))
               rdata = {{(DW-IO_W){1'b0}}, io_in[k*IO_W +: IO_W]};
            if (addr == AW'(OUT_BASE + k))
               rdata = {{(DW-IO_W){1'b0}}, io_out[k*IO_W +: IO_W]};
         end
      end
   end

endmodule

// File: rtl/sixop_ctrl.sv
module sixop_ctrl
   import sixop_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] opcode,
   input  logic       rp_zero,
   output ctl_t       ctl,
   output logic       fetch
);

   state_e state, nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_INIT;
      else        state <= nxt;
   end

   always_comb begin
      ctl      = '0;
      ctl.wsel = WD_MEM;
      ctl.alu  = ALU_PASS;
      nxt      = ST_FETCH;
      unique case (state)
         ST_INIT: ctl.pc_clr = 1'b1;
         ST_FETCH: begin
            ctl.ir_ld  = 1'b1;
            ctl.pc_inc = 1'b1;
            nxt        = ST_DECODE;
         end
         ST_DECODE: begin
            case (opcode)
               OPC_LOAD:  nxt = ST_LOAD;
               OPC_STORE: nxt = ST_STORE;
               OPC_ADD:   nxt = ST_ADD;
               OPC_LDC:   nxt = ST_LDC;
               OPC_SUB:   nxt = ST_SUB;
               OPC_JMPZ:  nxt = ST_JMPZ;
               default:   nxt = ST_NOP;
            endcase
         end
         ST_LOAD: begin
            ctl.rf_we = 1'b1;
            ctl.wsel  = WD_MEM;
         end
         ST_STORE: begin
            ctl.p_from_ra = 1'b1;
            ctl.d_wr      = 1'b1;
         end
         ST_ADD: begin
            ctl.rf_we = 1'b1;
            ctl.wsel  = WD_ALU;
            ctl.alu   = ALU_ADD;
         end
         ST_SUB: begin
            ctl.rf_we = 1'b1;
            ctl.wsel  = WD_ALU;
            ctl.alu   = ALU_SUB;
         end
         ST_LDC: begin
            ctl.rf_we = 1'b1;
            ctl.wsel  = WD_IMM;
         end
         ST_JMPZ: begin
            ctl.p_from_ra = 1'b1;
            ctl.pc_ld     = rp_zero;
         end
         default: ;
      endcase
   end

   assign fetch = (state == ST_FETCH);

endmodule

// File: rtl/sixop_cpu.sv
module sixop_cpu
   import sixop_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned RF_DEPTH   = 16,
   parameter int unsigned DMEM_DEPTH = 256,
   parameter int unsigned IMEM_DEPTH = 256,
   parameter int unsigned IN_BASE    = 240,
   parameter int unsigned OUT_BASE   = 248,
   parameter int unsigned IO_W       = 8,
   parameter int unsigned IO_PORTS   = 8,
   localparam int unsigned PC_W      = $clog2(IMEM_DEPTH),
   localparam int unsigned DA_W      = $clog2(DMEM_DEPTH),
   localparam int unsigned RA_W      = $clog2(RF_DEPTH),
   localparam int unsigned IOV_W     = IO_W * IO_PORTS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               imem_we,
   input  logic [PC_W-1:0]    imem_addr,
   input  logic [INSTR_W-1:0] imem_data,
   input  logic [IOV_W-1:0]   io_in,
   output logic [IOV_W-1:0]   io_out,
   output logic [PC_W-1:0]    pc_o,
   output logic               fetch_o
);

   if (DATA_W != INSTR_W) begin : g_bad_dw
      $error("sixop_cpu: DATA_W must equal the instruction width");
   end
   if (RF_DEPTH != 16) begin : g_bad_rf
      $error("sixop_cpu: register fields are 4 bits, RF_DEPTH must be 16");
   end
   if (DMEM_DEPTH != (1 << IMM_W)) begin : g_bad_dm
      $error("sixop_cpu: data addresses are 8 bits, DMEM_DEPTH must be 256");
   end
   if (PC_W < IMM_W || (1 << PC_W) != IMEM_DEPTH) begin : g_bad_im
      $error("sixop_cpu: IMEM_DEPTH must be a power of two of at least 256");
   end

   logic [INSTR_W-1:0] imem [IMEM_DEPTH];
   logic [INSTR_W-1:0] ir;
   logic [PC_W-1:0]    pc;
   ctl_t               ctl;
   logic               fetch;

   logic [RA_W-1:0]    ra, rb, rc;
   logic [IMM_W-1:0]   imm;
   logic [DATA_W-1:0]  p_data, q_data, alu_y, dm_rdata, rf_wdata;
   logic               rp_zero;
   logic [PC_W-1:0]    off_ext;
   logic               dm_we;
   logic               pc_ld;

   assign ra  = ir[11:8];
   assign rb  = ir[7:4];
   assign rc  = ir[3:0];
   assign imm = ir[IMM_W-1:0];

   always_ff @(posedge clk) begin
      if (imem_we) imem[imem_addr] <= imem_data;
   end

   if (PC_W == IMM_W) begin : g_off_same
      assign off_ext = imm;
   end else begin : g_off_sext
      assign off_ext = {{(PC_W-IMM_W){imm[IMM_W-1]}}, imm};
   end

   assign pc_ld = ctl.pc_ld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pc <= '0;
      else if (ctl.pc_clr) pc <= '0;
      else if (ctl.pc_ld)  pc <= pc + off_ext - 1'b1;
      else if (ctl.pc_inc) pc <= pc + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ir <= '0;
      else if (ctl.ir_ld) ir <= imem[pc];
   end

   sixop_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .opcode  (ir[15:12]),
      .rp_zero (rp_zero),
      .ctl     (ctl),
      .fetch   (fetch)
   );

   sixop_rf #(.DW(DATA_W), .DEPTH(RF_DEPTH)) u_rf (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (ctl.rf_we),
      .waddr  (ra),
      .wdata  (rf_wdata),
      .p_addr (ctl.p_from_ra ? ra : rb),
      .p_data (p_data),
      .q_addr (rc),
      .q_data (q_data)
   );

   assign rp_zero = (p_data == '0);

   sixop_alu #(.DW(DATA_W)) u_alu (
      .a   (p_data),
      .b   (q_data),
      .sel (ctl.alu),
      .y   (alu_y)
   );

   assign dm_we = ctl.d_wr;

   sixop_dmem #(
      .DW(DATA_W), .DEPTH(DMEM_DEPTH), .IN_BASE(IN_BASE),
      .OUT_BASE(OUT_BASE), .IO_W(IO_W), .IO_PORTS(IO_PORTS)
   ) u_dmem (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (dm_we),
      .addr   (imm[DA_W-1:0]),
      .wdata  (p_data),
      .rdata  (dm_rdata),
      .io_in  (io_in),
      .io_out (io_out)
   );

   always_comb begin
      unique case (ctl.wsel)
         WD_ALU:  rf_wdata = alu_y;
         WD_IMM:  rf_wdata = {{(DATA_W-IMM_W){1'b0}}, imm};
         default: rf_wdata = dm_rdata;
      endcase
   end

   assign pc_o    = pc;
   assign fetch_o = fetch;

endmodule

// File: rtl/sixop_cpu_chk.sv
module sixop_cpu_chk #(
   parameter int unsigned PC_W  = 8,
   parameter int unsigned IOV_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic [PC_W-1:0]  pc_o,
   input logic             fetch_o,
   input logic [IOV_W-1:0] io_out,
   input logic             dm_we,
   input logic             pc_ld
);

   // R1: reset holds the visible state at its cleared values
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |-> (pc_o == '0 && io_out == '0 && !fetch_o));

   // R2: fetch recurs exactly every third cycle
   a_r2_fetch_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_o |=> !fetch_o ##1 !fetch_o ##1 fetch_o);

   // R2: each fetch steps the program counter by one
   a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_o |=> pc_o == $past(pc_o) + 1'b1);

   // R7: outside fetch and a taken branch the program counter holds
   a_r7_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_o && !pc_ld) |=> $stable(pc_o));

   // R9: output bytes move only after a memory write
   a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !dm_we |=> $stable(io_out));

endmodule

bind sixop_cpu sixop_cpu_chk #(.PC_W(PC_W), .IOV_W(IOV_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .pc_o    (pc_o),
   .fetch_o (fetch_o),
   .io_out  (io_out),
   .dm_we   (dm_we),
   .pc_ld   (pc_ld)
);

// File: tb/tb_sixop_cpu.sv
`timescale 1ns/1ps
module tb_sixop_cpu;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        imem_we = 1'b0;
   logic [7:0]  imem_addr = '0;
   logic [15:0] imem_data = '0;
   logic [63:0] io_in = '0;
   logic [63:0] io_out;
   logic [7:0]  pc_o;
   logic        fetch_o;

   int n_chk = 0;
   int n_fail = 0;
   logic [15:0] prog [32];

   always #5 clk = ~clk;

   sixop_cpu dut (
      .clk(clk), .rst_n(rst_n), .imem_we(imem_we), .imem_addr(imem_addr),
      .imem_data(imem_data), .io_in(io_in), .io_out(io_out),
      .pc_o(pc_o), .fetch_o(fetch_o)
   );

   function automatic logic [15:0] e_ld(input logic [3:0] a, input logic [7:0] d);
      return {4'h0, a, d};
   endfunction
   function automatic logic [15:0] e_st(input logic [3:0] a, input logic [7:0] d);
      return {4'h1, a, d};
   endfunction
   function automatic logic [15:0] e_add(input logic [3:0] a, b, c);
      return {4'h2, a, b, c};
   endfunction
   function automatic logic [15:0] e_ldc(input logic [3:0] a, input logic [7:0] k);
      return {4'h3, a, k};
   endfunction
   function automatic logic [15:0] e_sub(input logic [3:0] a, b, c);
      return {4'h4, a, b, c};
   endfunction
   function automatic logic [15:0] e_jz(input logic [3:0] a, input logic [7:0] off);
      return {4'h5, a, off};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic load_prog(input int n);
      rst_n = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         imem_we   = 1'b1;
         imem_addr = 8'(i);
         imem_data = prog[i];
      end
      @(negedge clk);
      imem_we = 1'b0;
   endtask

   task automatic wait_fetch;
      for (int i = 0; i < 3; i++) begin
         if (fetch_o) break;
         @(negedge clk);
      end
   endtask

   task automatic build_fixed;
      prog[0]  = e_ldc(4'd1, 8'h00);
      prog[1]  = e_jz (4'd1, 8'd3);
      prog[2]  = e_ldc(4'd2, 8'hEE);
      prog[3]  = e_st (4'd2, 8'd251);
      prog[4]  = e_ldc(4'd3, 8'h05);
      prog[5]  = e_jz (4'd3, 8'd2);
      prog[6]  = e_st (4'd3, 8'd252);
      prog[7]  = e_ld (4'd4, 8'd242);
      prog[8]  = e_st (4'd4, 8'd253);
      prog[9]  = 16'hF123;
      prog[10] = 16'h6456;
      prog[11] = e_st (4'd4, 8'd254);
      prog[12] = e_st (4'd3, 8'd241);
      prog[13] = e_ld (4'd5, 8'd241);
      prog[14] = e_st (4'd5, 8'd255);
      prog[15] = e_ldc(4'd6, 8'h80);
      prog[16] = e_add(4'd7, 4'd6, 4'd6);
      prog[17] = e_ldc(4'd8, 8'h40);
      prog[18] = e_add(4'd8, 4'd8, 4'd8);
      prog[19] = e_add(4'd8, 4'd8, 4'd8);
      prog[20] = e_sub(4'd9, 4'd7, 4'd8);
      prog[21] = e_jz (4'd9, 8'd2);
      prog[22] = e_st (4'd6, 8'd250);
      prog[23] = e_jz (4'd1, 8'd2);
      prog[24] = e_jz (4'd15, 8'd0);
      prog[25] = e_jz (4'd1, 8'hFF);
   endtask

   task automatic run_fixed(input logic [63:0] pins, input bit cadence);
      logic [7:0] in1, in2;
      io_in = pins;
      in1 = pins[15:8];
      in2 = pins[23:16];
      build_fixed();
      load_prog(26);
      rst_n = 1'b1;
      for (int i = 0; i < 9; i++) begin
         @(negedge clk);
         if (cadence) chk(fetch_o == (i % 3 == 0), "R2 fetch cadence", 64'(fetch_o), 64'(i % 3 == 0));
         if (cadence && i == 0) chk(pc_o == 8'd0, "R1 first fetch address", 64'(pc_o), 64'd0);
      end
      repeat (110) @(negedge clk);
      wait_fetch();
      chk(pc_o == 8'd24, "R7 branches reach halt", 64'(pc_o), 64'd24);
      chk(io_out[31:24] == 8'h00, "R7 taken forward branch skips store", 64'(io_out[31:24]), 64'd0);
      chk(io_out[39:32] == 8'h05, "R7 untaken branch falls through", 64'(io_out[39:32]), 64'h05);
      chk(io_out[47:40] == in2, "R8 input byte read", 64'(io_out[47:40]), 64'(in2));
      chk(io_out[55:48] == in2, "R10 undefined opcodes leave registers", 64'(io_out[55:48]), 64'(in2));
      chk(io_out[63:56] == in1, "R8 store to input address ignored", 64'(io_out[63:56]), 64'(in1));
      chk(io_out[23:16] == 8'h00, "R6 constant zero-extended", 64'(io_out[23:16]), 64'd0);
      chk(io_out[15:0] == 16'h0000, "R9 unwritten output bytes stay zero", 64'(io_out[15:0]), 64'd0);
   endtask

   task automatic run_pair(input logic [7:0] x, input logic [7:0] y);
      logic [7:0] a, s, d;
      a = 8'((int'(x) + int'(y)) % 200);
      s = x + y;
      d = x - y;
      prog[0]  = e_ldc(4'd1, x);
      prog[1]  = e_ldc(4'd2, y);
      prog[2]  = e_add(4'd3, 4'd1, 4'd2);
      prog[3]  = e_sub(4'd4, 4'd1, 4'd2);
      prog[4]  = e_st (4'd3, 8'd248);
      prog[5]  = e_st (4'd4, 8'd249);
      prog[6]  = e_st (4'd3, a);
      prog[7]  = e_ld (4'd5, a);
      prog[8]  = e_st (4'd5, 8'd250);
      prog[9]  = e_ldc(4'd6, 8'h01);
      prog[10] = e_sub(4'd7, 4'd0, 4'd6);
      prog[11] = e_add(4'd8, 4'd7, 4'd6);
      prog[12] = e_jz (4'd8, 8'd2);
      prog[13] = e_st (4'd6, 8'd251);
      prog[14] = e_jz (4'd15, 8'd0);
      load_prog(15);
      rst_n = 1'b1;
      repeat (55) @(negedge clk);
      chk(io_out[7:0] == s, "R4 add result", 64'(io_out[7:0]), 64'(s));
      chk(io_out[15:8] == d, "R5 subtract result", 64'(io_out[15:8]), 64'(d));
      chk(io_out[23:16] == s, "R3 RAM store/load round trip", 64'(io_out[23:16]), 64'(s));
      chk(io_out[31:24] == 8'h00, "R4 0xFFFF+1 wraps to zero", 64'(io_out[31:24]), 64'd0);
   endtask

   initial begin
      #1_500_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      @(negedge clk);
      chk(pc_o == 8'd0 && !fetch_o, "R1 reset pc and fetch", 64'({pc_o, fetch_o}), 64'd0);
      chk(io_out == 64'd0, "R1 reset outputs", io_out, 64'd0);

      run_fixed(64'h0123_4567_89AB_CDEF, 1'b1);

      rst_n = 1'b0;
      @(negedge clk);
      chk(io_out == 64'd0, "R1 reset clears outputs", io_out, 64'd0);
      chk(pc_o == 8'd0 && !fetch_o, "R1 reset clears pc", 64'({pc_o, fetch_o}), 64'd0);

      for (int xi = 0; xi < 256; xi += 15) begin
         for (int yi = 0; yi < 256; yi += 23) begin
            run_pair(8'(xi), 8'(yi));
         end
      end
      run_pair(8'hFF, 8'hFF);
      run_pair(8'h00, 8'h01);

      run_fixed(64'hA55A_3C00_FF81_7E42, 1'b0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule